// File: doc/BRIEF.md
# Truth-Table Programmed Ripple ALU

This block is a combinational arithmetic and logic unit built from identical one-bit slices. No slice contains a fixed function decoder. Each slice is steered by three 4-bit truth tables. The propagate table and the kill table are evaluated on the operand bits a and b. A carry cell uses them to turn the incoming carry into the outgoing carry. The result table is evaluated on the propagate bit and the incoming carry to form the result bit. Any two-input logic function can be produced by choosing these three tables, and so can any add, subtract, increment, decrement or negate that rides the carry chain.

A small combinational decoder turns a 5-bit operation code into the three tables. It also chooses the carry fed into slice 0: zero, one, or the external carry input. Slices are chained by ripple: the carry out of slice i is the carry in of slice i+1, and the carry out of the top slice leaves the block. The width is a parameter. The block holds no state and has no clock.

Top module: `ttalu_core`

## Requirements
- R1: Bitwise codes produce the stated function on every bit with `cout` = 0: code 0 gives a, 1 gives b, 2 gives ~a, 3 gives ~b, 4 gives a^b, 5 gives a|b, 6 gives a&b, 7 gives ~(a&b), 8 gives ~(a^b).
- R2: Code 9 gives an all-zero result and code 10 gives an all-ones result, both with `cout` = 0.
- R3: Code 11 gives a+1 and code 12 gives b+1, each modulo 2^W, with `cout` equal to the carry out of the addition.
- R4: Code 13 gives a-1 and code 14 gives b-1, each modulo 2^W, with `cout` = 1 exactly when the operand is zero (borrow).
- R5: Code 15 gives -a and code 16 gives -b in two's complement, with `cout` = 1 exactly when the operand is zero.
- R6: Code 17 gives a+b modulo 2^W, with `cout` equal to bit W of the full sum.
- R7: Code 18 gives a+b+`ext_cin`, with `cout` equal to bit W of the full sum, for both values of `ext_cin`.
- R8: Code 19 gives a-b modulo 2^W, with `cout` = 1 exactly when a < b.
- R9: Code 20 gives a-b-`ext_cin` modulo 2^W, with `cout` = 1 exactly when a < b+`ext_cin`, for both values of `ext_cin`.
- R10: Code 21 gives b-a modulo 2^W, with `cout` = 1 exactly when b < a.
- R11: For every code other than 18 and 20, `ext_cin` has no effect on `y` or `cout`.
- R12: Codes 22 to 31 select all-zero tables, which gives `y` = 0 and `cout` = 1.
- R13: A one-bit instance (W = 1) obeys R1 to R12 with the operands truncated to one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 5 | Operation select, codes 0 to 21, others unused |
| a | input | W | Operand a |
| b | input | W | Operand b |
| ext_cin | input | 1 | External carry/borrow in, used by codes 18 and 20 |
| y | output | W | Result |
| cout | output | 1 | Carry or borrow out of the top slice |

## Verification
A wrong table entry in the decoder changes `y` at once. It appears in the same evaluation as the operand pattern that selects that table index, so every code is swept over all operand pairs and both carry-in values. A fault in a carry cell or in the ripple link shows only when a carry actually travels. It reaches the top bits and `cout` only for operands that propagate across the faulty slice. For that reason full-width carry patterns such as all-ones plus one and zero minus one are part of the exhaustive sweep.

// File: rtl/ttalu_pkg.sv
// Package: shared operation codes, control word type and the truth-table
// lookup used by every slice. Assumes tables are indexed {x,y}: bit 3 for
// (1,1), bit 2 for (1,0), bit 1 for (0,1), bit 0 for (0,0).
package ttalu_pkg;

    localparam int OPC_W = 5;

    localparam logic [OPC_W-1:0] OPC_PASS_A   = 5'd0;
    localparam logic [OPC_W-1:0] OPC_PASS_B   = 5'd1;
    localparam logic [OPC_W-1:0] OPC_INV_A    = 5'd2;
    localparam logic [OPC_W-1:0] OPC_INV_B    = 5'd3;
    localparam logic [OPC_W-1:0] OPC_XOR      = 5'd4;
    localparam logic [OPC_W-1:0] OPC_OR       = 5'd5;
    localparam logic [OPC_W-1:0] OPC_AND      = 5'd6;
    localparam logic [OPC_W-1:0] OPC_NAND     = 5'd7;
    localparam logic [OPC_W-1:0] OPC_XNOR     = 5'd8;
    localparam logic [OPC_W-1:0] OPC_ZERO     = 5'd9;
    localparam logic [OPC_W-1:0] OPC_ONES     = 5'd10;
    localparam logic [OPC_W-1:0] OPC_INC_A    = 5'd11;
    localparam logic [OPC_W-1:0] OPC_INC_B    = 5'd12;
    localparam logic [OPC_W-1:0] OPC_DEC_A    = 5'd13;
    localparam logic [OPC_W-1:0] OPC_DEC_B    = 5'd14;
    localparam logic [OPC_W-1:0] OPC_NEG_A    = 5'd15;
    localparam logic [OPC_W-1:0] OPC_NEG_B    = 5'd16;
    localparam logic [OPC_W-1:0] OPC_ADD      = 5'd17;
    localparam logic [OPC_W-1:0] OPC_ADDC     = 5'd18;
    localparam logic [OPC_W-1:0] OPC_SUB      = 5'd19;
    localparam logic [OPC_W-1:0] OPC_SUBB     = 5'd20;
    localparam logic [OPC_W-1:0] OPC_RSUB     = 5'd21;
    localparam logic [OPC_W-1:0] OPC_LAST     = OPC_RSUB;

    // Common table values
    localparam logic [3:0] TT_ALL  = 4'b1111;
    localparam logic [3:0] TT_X    = 4'b1100;  // first input
    localparam logic [3:0] TT_Y    = 4'b1010;  // second input
    localparam logic [3:0] TT_NX   = 4'b0011;
    localparam logic [3:0] TT_NY   = 4'b0101;
    localparam logic [3:0] TT_XOR  = 4'b0110;
    localparam logic [3:0] TT_XNOR = 4'b1001;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_EXT  = 2'd2
    } cin_sel_e;

    typedef struct packed {
        logic [3:0] prop_tt;
        logic [3:0] kill_tt;
        logic [3:0] res_tt;
        cin_sel_e   cin_sel;
    } ctl_t;

    // Evaluate a 4-entry truth table on two inputs.
    function automatic logic tt_eval(input logic [3:0] tt, input logic x, input logic y);
        return tt[{x, y}];
    endfunction

endpackage

// File: rtl/ttalu_ctl.sv
// Module: operation decoder. Purely combinational; maps an operation code to
// the propagate, kill and result tables plus the slice-0 carry source.
// Assumes codes above OPC_LAST are unused and must yield all-zero tables.
module ttalu_ctl
    import ttalu_pkg::*;
(
    input  logic [OPC_W-1:0] op_code,
    output ctl_t             ctl
);

    // Table selection per operation code
    always_comb begin
        ctl = '{prop_tt: 4'b0000, kill_tt: 4'b0000, res_tt: 4'b0000, cin_sel: CIN_ZERO};
        if (op_code <= OPC_ONES) begin
            ctl.kill_tt = TT_ALL;
            ctl.res_tt  = TT_X;
        end
        case (op_code)
            OPC_PASS_A: ctl.prop_tt = TT_X;
            OPC_PASS_B: ctl.prop_tt = TT_Y;
            OPC_INV_A:  ctl.prop_tt = TT_NX;
            OPC_INV_B:  ctl.prop_tt = TT_NY;
            OPC_XOR:    ctl.prop_tt = TT_XOR;
            OPC_OR:     ctl.prop_tt = 4'b1110;
            OPC_AND:    ctl.prop_tt = 4'b1000;
            OPC_NAND:   ctl.prop_tt = 4'b0111;
            OPC_XNOR:   ctl.prop_tt = TT_XNOR;
            OPC_ZERO:   ctl.prop_tt = 4'b0000;
            OPC_ONES:   ctl.prop_tt = TT_ALL;
            OPC_INC_A:  ctl = '{prop_tt: TT_X,  kill_tt: TT_NX, res_tt: TT_XOR,  cin_sel: CIN_ONE};
            OPC_INC_B:  ctl = '{prop_tt: TT_Y,  kill_tt: TT_NY, res_tt: TT_XOR,  cin_sel: CIN_ONE};
            OPC_DEC_A:  ctl = '{prop_tt: TT_NX, kill_tt: TT_X,  res_tt: TT_XNOR, cin_sel: CIN_ONE};
            OPC_DEC_B:  ctl = '{prop_tt: TT_NY, kill_tt: TT_Y,  res_tt: TT_XNOR, cin_sel: CIN_ONE};
            OPC_NEG_A:  ctl = '{prop_tt: TT_NX, kill_tt: TT_X,  res_tt: TT_XOR,  cin_sel: CIN_ONE};
            OPC_NEG_B:  ctl = '{prop_tt: TT_NY, kill_tt: TT_Y,  res_tt: TT_XOR,  cin_sel: CIN_ONE};
            OPC_ADD:    ctl = '{prop_tt: TT_XOR,  kill_tt: 4'b0001, res_tt: TT_XOR,  cin_sel: CIN_ZERO};
            OPC_ADDC:   ctl = '{prop_tt: TT_XOR,  kill_tt: 4'b0001, res_tt: TT_XOR,  cin_sel: CIN_EXT};
            OPC_SUB:    ctl = '{prop_tt: TT_XNOR, kill_tt: 4'b0100, res_tt: TT_XNOR, cin_sel: CIN_ZERO};
            OPC_SUBB:   ctl = '{prop_tt: TT_XNOR, kill_tt: 4'b0100, res_tt: TT_XNOR, cin_sel: CIN_EXT};
            OPC_RSUB:   ctl = '{prop_tt: TT_XNOR, kill_tt: 4'b0010, res_tt: TT_XNOR, cin_sel: CIN_ZERO};
            default:    ;
        endcase
    end

    // Guard the decoder's grouping of codes
    always_comb begin
        if (op_code <= OPC_ONES) begin
            p_logic_ctl_r1: assert (ctl.kill_tt == TT_ALL && ctl.res_tt == TT_X && ctl.cin_sel == CIN_ZERO)
                else $error("bitwise code with arithmetic tables");
        end
        if (op_code >= OPC_INC_A && op_code <= OPC_NEG_B) begin
            p_forced_cin_r3: assert (ctl.cin_sel == CIN_ONE)
                else $error("unary arithmetic code without forced carry");
        end
        if (op_code > OPC_LAST) begin
            p_unused_zero_r12: assert (ctl.prop_tt == 4'b0000 && ctl.kill_tt == 4'b0000 &&
                                       ctl.res_tt == 4'b0000 && ctl.cin_sel == CIN_ZERO)
                else $error("unused code produced non-zero tables");
        end
        p_ext_only_r11: assert ((ctl.cin_sel == CIN_EXT) == (op_code == OPC_ADDC || op_code == OPC_SUBB))
            else $error("external carry chosen for wrong code");
    end

endmodule

// File: rtl/ttalu_carry.sv
// Module: propagate/kill carry cell. Passes the incoming carry when the
// propagate bit is set, kills it when only kill is set, and generates a
// carry when neither is set.
module ttalu_carry (
    input  logic prop,
    input  logic kill,
    input  logic cin,
    output logic cout
);

    // Carry selection from propagate and kill
    always_comb begin
        case ({prop, kill})
            2'b10, 2'b11: cout = cin;
            2'b01:        cout = 1'b0;
            default:      cout = 1'b1;
        endcase
    end

endmodule

// File: rtl/ttalu_slice.sv
// Module: one bit of the ALU. Evaluates the propagate and kill tables on the
// operand bits, runs the carry cell, then evaluates the result table on
// (propagate, carry in). Assumes the tables are stable for the whole slice.
module ttalu_slice
    import ttalu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       cin,
    input  logic [3:0] prop_tt,
    input  logic [3:0] kill_tt,
    input  logic [3:0] res_tt,
    output logic       y_bit,
    output logic       cout
);

    logic prop;
    logic kill;

    // Operand-side table lookups
    always_comb begin
        prop = tt_eval(prop_tt, a_bit, b_bit);
        kill = tt_eval(kill_tt, a_bit, b_bit);
    end

    ttalu_carry u_carry (
        .prop (prop),
        .kill (kill),
        .cin  (cin),
        .cout (cout)
    );

    // Result lookup on propagate and incoming carry
    always_comb begin
        y_bit = tt_eval(res_tt, prop, cin);
    end

    // Carry cell behaviour seen from the slice
    always_comb begin
        if (prop) begin
            p_carry_pass_r6: assert (cout == cin) else $error("carry not propagated");
        end else if (kill) begin
            p_carry_kill_r8: assert (cout == 1'b0) else $error("carry not killed");
        end else begin
            p_carry_gen_r6: assert (cout == 1'b1) else $error("carry not generated");
        end
    end

endmodule

// File: rtl/ttalu_core.sv
// Module: top of the truth-table ALU. Decodes the operation code, picks the
// slice-0 carry, and ripples the carry through W identical slices. Holds no
// state, so it has neither clock nor reset.
module ttalu_core
    import ttalu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [OPC_W-1:0] op_code,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic             ext_cin,
    output logic [W-1:0]     y,
    output logic             cout
);

    localparam int CHAIN_N = W + 1;

    ctl_t               ctl;
    logic [CHAIN_N-1:0] carry;

    ttalu_ctl u_ctl (
        .op_code (op_code),
        .ctl     (ctl)
    );

    // Slice-0 carry source
    always_comb begin
        case (ctl.cin_sel)
            CIN_ONE: carry[0] = 1'b1;
            CIN_EXT: carry[0] = ext_cin;
            default: carry[0] = 1'b0;
        endcase
    end

    for (genvar i = 0; i < W; i++) begin : g_slice
        ttalu_slice u_slice (
            .a_bit   (a[i]),
            .b_bit   (b[i]),
            .cin     (carry[i]),
            .prop_tt (ctl.prop_tt),
            .kill_tt (ctl.kill_tt),
            .res_tt  (ctl.res_tt),
            .y_bit   (y[i]),
            .cout    (carry[i+1])
        );
    end

    assign cout = carry[W];

    // End-to-end arithmetic checks at the ports
    always_comb begin
        if (op_code == OPC_ADD) begin
            p_add_sum_r6: assert ({cout, y} == ({1'b0, a} + {1'b0, b}))
                else $error("add result mismatch");
        end
        if (op_code == OPC_ADDC) begin
            p_addc_sum_r7: assert ({cout, y} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ext_cin}))
                else $error("add-with-carry result mismatch");
        end
        if (op_code == OPC_XOR) begin
            p_xor_bits_r1: assert (y == (a ^ b) && !cout) else $error("xor mismatch");
        end
        if (op_code > OPC_LAST) begin
            p_unused_out_r12: assert (y == '0 && cout) else $error("unused code output");
        end
    end

endmodule

// File: tb/ttalu_core_tb.sv
module ttalu_core_tb;

    localparam int W4 = 4;
    localparam int W1 = 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic [4:0]    op_code = '0;
    logic [W4-1:0] a = '0;
    logic [W4-1:0] b = '0;
    logic          ext_cin = 1'b0;
    logic [W4-1:0] y4;
    logic          c4;
    logic [W1-1:0] y1;
    logic          c1;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    ttalu_core #(.W(W4)) u_dut (
        .op_code (op_code), .a (a), .b (b), .ext_cin (ext_cin), .y (y4), .cout (c4)
    );

    ttalu_core #(.W(W1)) u_dut1 (
        .op_code (op_code), .a (a[0:0]), .b (b[0:0]), .ext_cin (ext_cin), .y (y1), .cout (c1)
    );

    // Reference model computed from the requirements
    function automatic void ref_calc(input int op, input int w, input int av, input int bv,
                                     input int ci, output int ry, output int rc);
        int m;
        int s;
        m  = (1 << w) - 1;
        av = av & m;
        bv = bv & m;
        rc = 0;
        s  = 0;
        case (op)
            0:  s = av;
            1:  s = bv;
            2:  s = ~av;
            3:  s = ~bv;
            4:  s = av ^ bv;
            5:  s = av | bv;
            6:  s = av & bv;
            7:  s = ~(av & bv);
            8:  s = ~(av ^ bv);
            9:  s = 0;
            10: s = m;
            11: begin s = av + 1; rc = (s >> w) & 1; end
            12: begin s = bv + 1; rc = (s >> w) & 1; end
            13: begin s = av - 1; rc = (av == 0) ? 1 : 0; end
            14: begin s = bv - 1; rc = (bv == 0) ? 1 : 0; end
            15: begin s = -av; rc = (av == 0) ? 1 : 0; end
            16: begin s = -bv; rc = (bv == 0) ? 1 : 0; end
            17: begin s = av + bv; rc = (s >> w) & 1; end
            18: begin s = av + bv + ci; rc = (s >> w) & 1; end
            19: begin s = av - bv; rc = (av < bv) ? 1 : 0; end
            20: begin s = av - bv - ci; rc = (av < bv + ci) ? 1 : 0; end
            21: begin s = bv - av; rc = (bv < av) ? 1 : 0; end
            default: begin s = 0; rc = 1; end
        endcase
        ry = s & m;
    endfunction

    function automatic string req_tag(input int op, input int ci, input int w);
        string t;
        if (op <= 8)       t = "R1";
        else if (op <= 10) t = "R2";
        else if (op <= 12) t = "R3";
        else if (op <= 14) t = "R4";
        else if (op <= 16) t = "R5";
        else if (op == 17) t = "R6";
        else if (op == 18) t = "R7";
        else if (op == 19) t = "R8";
        else if (op == 20) t = "R9";
        else if (op == 21) t = "R10";
        else               t = "R12";
        if (ci != 0 && op != 18 && op != 20) t = {t, "/R11"};
        if (w == 1) t = {t, "/R13"};
        return t;
    endfunction

    // Apply one vector, then compare both instances mid-cycle
    task automatic apply_check(input int op, input int av, input int bv, input int ci);
        int ey;
        int ec;
        @(posedge clk);
        op_code = op[4:0];
        a       = av[3:0];
        b       = bv[3:0];
        ext_cin = ci[0];
        @(negedge clk);
        ref_calc(op, W4, av, bv, ci, ey, ec);
        n_run++;
        if (int'(y4) != ey || int'(c4) != ec) begin
            n_fail++;
            $display("FAIL %s W=4 op=%0d a=%0d b=%0d ci=%0d: got y=%0d c=%0d, expected y=%0d c=%0d",
                     req_tag(op, ci, W4), op, av, bv, ci, y4, c4, ey, ec);
        end
        ref_calc(op, W1, av, bv, ci, ey, ec);
        n_run++;
        if (int'(y1) != ey || int'(c1) != ec) begin
            n_fail++;
            $display("FAIL %s W=1 op=%0d a=%0d b=%0d ci=%0d: got y=%0d c=%0d, expected y=%0d c=%0d",
                     req_tag(op, ci, W1), op, av, bv, ci, y1, c1, ey, ec);
        end
    endtask

    // Watchdog
    initial begin
        #(8 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17C0DE));
        // Initial state with all-zero inputs: pass-through of a = 0 (R1)
        @(negedge clk);
        n_run++;
        if (y4 != 4'd0 || c4 != 1'b0) begin
            n_fail++;
            $display("FAIL R1 initial: got y=%0d c=%0d, expected y=0 c=0", y4, c4);
        end
        // Directed corners: full ripple carry and borrow (R6, R7, R9, R4, R5)
        apply_check(17, 15, 1, 0);
        apply_check(18, 15, 15, 1);
        apply_check(20, 0, 15, 1);
        apply_check(13, 0, 0, 0);
        apply_check(15, 0, 0, 1);
        apply_check(11, 15, 0, 0);
        // Exhaustive sweep over all codes, operand pairs and carry values
        for (int op = 0; op < 32; op++)
            for (int ci = 0; ci < 2; ci++)
                for (int av = 0; av < 16; av++)
                    for (int bv = 0; bv < 16; bv++)
                        apply_check(op, av, bv, ci);
        // Random mix including unused codes
        for (int n = 0; n < 3000; n++)
            apply_check(int'($urandom_range(31, 0)), int'($urandom_range(15, 0)),
                        int'($urandom_range(15, 0)), int'($urandom_range(1, 0)));
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule